// File: doc/BRIEF.md
# Dual-Channel Serial Audio DAC Transmitter

This block feeds a stereo serial digital-to-analogue converter that has one shift clock, a separate serial data line for each channel and a separate update strobe for each channel. A producer hands over a pair of 16-bit two's complement samples through a valid/ready handshake. The block shifts both words out together, most significant bit first. It then raises both update strobes so that the converter copies its shift registers to its analogue outputs.

Each word occupies a frame of 18 bit periods. Sixteen of them carry data and the bit clock pulses in each of these. In the 17th the strobes are high. The 18th is a quiet slot before the next word begins. The bit clock is held low in both of these extra slots, so the converter sees exactly 16 rising edges per word. The bit period is a runtime divisor of the system clock. Software picks it so that the word rate equals the sample rate times the oversampling factor, and so that the pulse rate stays at or below 13.5 MHz: divisor = f_sys / (f_sample × oversampling × 18). If the producer has not supplied a new pair by the start of a frame, the previous pair is sent again.

Top module: `dual_dac_tx`

## Requirements
- R1: Data lines change only together with a falling bit clock edge; they are stable at every rising edge, which is where the converter samples.
- R2: Each word is 16 bits, two's complement, most significant bit first; the left sample goes out on ser_left and the right sample on ser_right, bit for bit in step.
- R3: Between two strobe pulses the bit clock rises exactly 16 times; it is held low for the two bit periods of the strobe and quiet slots.
- R4: Both strobes rise on the falling bit clock edge that follows the 16th rising edge and stay high for exactly one bit period. They fall one bit period before the next most significant bit is driven. The clock does not pulse while they are high, and both data lines are low.
- R5: One bit period lasts an effective divisor number of system clock cycles, with the bit clock high for half of it.
- R6: A divisor value that is odd, zero or one is treated as 2.
- R7: s_ready is high when enabled and the one-entry holding buffer is empty; a pair accepted on a valid-and-ready cycle is sent in the next frame, and pairs are sent in the order accepted.
- R8: When no new pair is held at a frame start, the previous pair is repeated; after reset the previous pair is zero.
- R9: While en is low, all five converter outputs and s_ready are low and the frame restarts. After en rises, the first rising bit clock edge comes 1.5 bit periods later, so the first word begins one bit period after enable.
- R10: A pair offered in the very cycle a frame starts, with the buffer empty, is loaded straight into that frame and is not sent a second time from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces the idle state |
| div_cfg | input | DIV_W | Bit period in system clock cycles (even, at least 2) |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding buffer can take a pair |
| s_left | input | WORD_W | Left sample, two's complement |
| s_right | input | WORD_W | Right sample, two's complement |
| bit_clk | output | 1 | Shift clock to the converter |
| ser_left | output | 1 | Left serial data |
| ser_right | output | 1 | Right serial data |
| lat_left | output | 1 | Left update strobe, active on its falling edge |
| lat_right | output | 1 | Right update strobe, active on its falling edge |

## Verification
Two functions can fall in the same cycle: the frame-start load that takes a word from the holding buffer, and the acceptance of a new pair from the producer. The bench watches for a strobe fall, which is observable at the ports. It counts one bit period minus one cycle from there, and offers a fresh pair in exactly the cycle of the next frame start. It then judges that the very next captured word is that pair, and that a second pair sent afterwards follows at once with no extra copy of the first. A behavioural converter model in the bench shifts on observed rising edges and captures on strobe falls. All word contents and timing widths are judged from what that model records.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned EXTRA_SLOTS = 2;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_LATCH = 2'd1,
    PH_REST  = 2'd2
  } frame_phase_e;
endpackage

// File: rtl/dac_bitclk_div.sv
module dac_bitclk_div #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] per;
  logic [DIV_W-1:0] per_m1;
  logic [DIV_W-1:0] half_m1;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // effective period: odd or below two falls back to two
  always_comb begin
    if (div_cfg[0] || (div_cfg < DIV_W'(2))) per = DIV_W'(2);
    else                                     per = div_cfg;
    per_m1  = per - DIV_W'(1);
    half_m1 = (per >> 1) - DIV_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                  cnt_d = '0;
    else if (cnt_q >= per_m1) cnt_d = '0;
    else                      cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rise_evt = en && (cnt_q == half_m1);
  assign fall_evt = en && (cnt_q >= per_m1);

  // R5: a bit period is never shorter than two system cycles
  p_fall_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
endmodule

// File: rtl/dac_sample_buf.sv
module dac_sample_buf #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  input  logic              take,
  output logic [WORD_W-1:0] cur_left,
  output logic [WORD_W-1:0] cur_right
);
  logic              pend_full_q, pend_full_d;
  logic [WORD_W-1:0] pend_l_q, pend_r_q;
  logic [WORD_W-1:0] last_l_q, last_r_q;
  logic              hs;
  logic              pend_we;

  assign s_ready = en && !pend_full_q;
  assign hs      = s_valid && s_ready;
  assign pend_we = hs && !take;

  // word handed to the serializer at a frame start
  always_comb begin
    if (pend_full_q) begin
      cur_left  = pend_l_q;
      cur_right = pend_r_q;
    end else if (hs) begin
      cur_left  = s_left;
      cur_right = s_right;
    end else begin
      cur_left  = last_l_q;
      cur_right = last_r_q;
    end
  end

  always_comb begin
    pend_full_d = pend_full_q;
    if (!en)         pend_full_d = 1'b0;
    else if (take)   pend_full_d = 1'b0;
    else if (hs)     pend_full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_full_q <= 1'b0;
    else        pend_full_q <= pend_full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
    end else if (pend_we) begin
      pend_l_q <= s_left;
      pend_r_q <= s_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_l_q <= '0;
      last_r_q <= '0;
    end else if (take) begin
      last_l_q <= cur_left;
      last_r_q <= cur_right;
    end
  end

  // R7: a frame start empties a full buffer
  p_take_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend_full_q) |=> !pend_full_q);
  // R10: a pair loaded straight into a frame is not also buffered
  p_bypass_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hs) |=> !pend_full_q);
endmodule

// File: rtl/dac_frame_ser.sv
module dac_frame_ser
  import dac_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic [WORD_W-1:0] cur_left,
  input  logic [WORD_W-1:0] cur_right,
  output logic              take,
  output logic              bit_clk,
  output logic              ser_left,
  output logic              ser_right,
  output logic              latch
);
  localparam int unsigned FRAME      = WORD_W + EXTRA_SLOTS;
  localparam int unsigned SLOT_W     = $clog2(FRAME);
  localparam int unsigned LAST_BIT   = WORD_W - 1;
  localparam int unsigned LATCH_SLOT = WORD_W;
  localparam int unsigned REST_SLOT  = WORD_W + 1;

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [WORD_W-1:0] sh_l_q, sh_l_d, sh_r_q, sh_r_d;
  logic              bclk_q, bclk_d;
  logic              latch_q, latch_d;
  frame_phase_e      phase;

  always_comb begin
    if (slot_q < SLOT_W'(WORD_W))          phase = PH_DATA;
    else if (slot_q == SLOT_W'(LATCH_SLOT)) phase = PH_LATCH;
    else                                    phase = PH_REST;
  end

  assign take = fall_evt && (phase == PH_REST);

  always_comb begin
    slot_d  = slot_q;
    sh_l_d  = sh_l_q;
    sh_r_d  = sh_r_q;
    bclk_d  = bclk_q;
    latch_d = latch_q;
    if (!en) begin
      slot_d  = SLOT_W'(REST_SLOT);
      sh_l_d  = '0;
      sh_r_d  = '0;
      bclk_d  = 1'b0;
      latch_d = 1'b0;
    end else begin
      if (rise_evt && (phase == PH_DATA)) bclk_d = 1'b1;
      if (fall_evt) begin
        bclk_d  = 1'b0;
        latch_d = (slot_q == SLOT_W'(LAST_BIT));
        if (take) begin
          slot_d = '0;
          sh_l_d = cur_left;
          sh_r_d = cur_right;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
          sh_l_d = {sh_l_q[WORD_W-2:0], 1'b0};
          sh_r_d = {sh_r_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_W'(REST_SLOT);
      sh_l_q  <= '0;
      sh_r_q  <= '0;
      bclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      sh_l_q  <= sh_l_d;
      sh_r_q  <= sh_r_d;
      bclk_q  <= bclk_d;
      latch_q <= latch_d;
    end
  end

  assign bit_clk   = bclk_q;
  assign ser_left  = sh_l_q[WORD_W-1];
  assign ser_right = sh_r_q[WORD_W-1];
  assign latch     = latch_q;

  // R1: data does not move on the edge where the converter samples
  p_data_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_q) |-> ($stable(sh_l_q[WORD_W-1]) && $stable(sh_r_q[WORD_W-1])));
  // R4: strobe interval is clock-quiet with low data
  p_latch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> (!bclk_q && !sh_l_q[WORD_W-1] && !sh_r_q[WORD_W-1]));
  // R4: strobe never a single-cycle glitch
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |=> latch_q);
  // R9: idle outputs low once disabled
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk_q && !latch_q && !sh_l_q[WORD_W-1] && !sh_r_q[WORD_W-1]));
endmodule

// File: rtl/dual_dac_tx.sv
module dual_dac_tx
  import dac_tx_pkg::*;
#(
  parameter int unsigned WORD_W = SAMPLE_W,
  parameter int unsigned DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  output logic              bit_clk,
  output logic              ser_left,
  output logic              ser_right,
  output logic              lat_left,
  output logic              lat_right
);
  logic              rise_evt, fall_evt, take, latch;
  logic [WORD_W-1:0] cur_left, cur_right;

  dac_bitclk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .div_cfg  (div_cfg),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  dac_sample_buf #(.WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_left    (s_left),
    .s_right   (s_right),
    .take      (take),
    .cur_left  (cur_left),
    .cur_right (cur_right)
  );

  dac_frame_ser #(.WORD_W(WORD_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .cur_left  (cur_left),
    .cur_right (cur_right),
    .take      (take),
    .bit_clk   (bit_clk),
    .ser_left  (ser_left),
    .ser_right (ser_right),
    .latch     (latch)
  );

  assign lat_left  = latch;
  assign lat_right = latch;
endmodule

// File: tb/dual_dac_tx_tb.sv
module dual_dac_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [11:0] div_cfg = 12'd4;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_left = '0;
  logic [15:0] s_right = '0;
  logic        bit_clk, ser_left, ser_right, lat_left, lat_right;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_dac_tx u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_cfg(div_cfg),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bit_clk(bit_clk), .ser_left(ser_left), .ser_right(ser_right),
    .lat_left(lat_left), .lat_right(lat_right)
  );

  // converter model and timing monitor
  logic [15:0] cap_l [0:511];
  logic [15:0] cap_r [0:511];
  int cap_n = 0;
  logic [15:0] m_l, m_r;
  logic p_bclk, p_ll, p_dl, p_dr;
  int bitcnt, hi_run, ll_run, rr_run;
  int last_hi = 0, last_llw = 0, last_rr = 0;
  int bad_bits = 0, viol = 0, lat_mis = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_l = '0; m_r = '0; p_bclk = 0; p_ll = 0; p_dl = 0; p_dr = 0;
      bitcnt = 0; hi_run = 0; ll_run = 0; rr_run = 0;
    end else begin
      rr_run++;
      if (bit_clk && !p_bclk) begin
        if (bitcnt > 0) last_rr = rr_run;
        rr_run = 0;
        m_l = {m_l[14:0], ser_left};
        m_r = {m_r[14:0], ser_right};
        bitcnt++;
      end
      if (bit_clk) hi_run++;
      else if (p_bclk) begin last_hi = hi_run; hi_run = 0; end
      if (bit_clk && (ser_left !== p_dl || ser_right !== p_dr)) viol++;
      if (lat_left && !p_ll && bit_clk) viol++;
      if (lat_left !== lat_right) lat_mis++;
      if (lat_left) ll_run++;
      else if (p_ll) begin
        last_llw = ll_run; ll_run = 0;
        if (en) begin
          if (bitcnt != 16) bad_bits++;
          if (cap_n < 512) begin cap_l[cap_n] = m_l; cap_r[cap_n] = m_r; end
          cap_n++;
        end
        bitcnt = 0;
      end
      if (!en) begin bitcnt = 0; hi_run = 0; end
      p_bclk = bit_clk; p_ll = lat_left; p_dl = ser_left; p_dr = ser_right;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] l, input logic [15:0] r);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) step();
    step();
    s_valid = 1'b0;
  endtask

  task automatic wait_caps(input int target);
    while (cap_n < target) step();
  endtask

  logic [31:0] ex [0:7];

  // walk captures from start: skip repeats of prev, then n expected words, then one repeat
  task automatic expect_seq(input string req, input int start, input logic [31:0] prev, input int n);
    int j = start;
    int k = 0;
    while (k < n) begin
      wait_caps(j + 1);
      if (k == 0 && {cap_l[j], cap_r[j]} == prev) j++;
      else begin
        chk(req, {cap_l[j], cap_r[j]}, ex[k]);
        k++; j++;
      end
    end
    wait_caps(j + 1);
    chk("R8 repeat of last pair", {cap_l[j], cap_r[j]}, ex[n-1]);
  endtask

  task automatic t_reset();
    chk("R9 reset outputs low", {27'd0, bit_clk, ser_left, ser_right, lat_left, lat_right}, 32'd0);
    chk("R9 reset s_ready low", {31'd0, s_ready}, 32'd0);
  endtask

  task automatic t_idle_zero();
    int c0;
    div_cfg = 12'd4; en = 1'b1;
    c0 = cap_n;
    wait_caps(c0 + 2);
    chk("R8 zero after reset", {cap_l[c0], cap_r[c0]}, 32'd0);
    chk("R3 sixteen edges per word", bad_bits, 0);
  endtask

  task automatic t_stream();
    int c0 = cap_n;
    ex[0] = 32'h8000_7FFF; ex[1] = 32'h7FFF_8000;
    ex[2] = 32'h0001_FFFF; ex[3] = 32'hA5C3_3C5A;
    for (int i = 0; i < 4; i++) send(ex[i][31:16], ex[i][15:0]);
    expect_seq("R2 R7 ordered words", c0, 32'd0, 4);
    chk("R1 data stable at rising edges", viol, 0);
    chk("R3 sixteen edges per word", bad_bits, 0);
    chk("R4 strobe width one period", last_llw, 4);
    chk("R4 strobes identical", lat_mis, 0);
    chk("R5 high half of period 4", last_hi, 2);
    chk("R5 rise spacing period 4", last_rr, 4);
  endtask

  task automatic t_div(input logic [11:0] d, input int p, input logic [31:0] prev, input logic [31:0] w);
    int c0, st;
    en = 1'b0; step();
    div_cfg = d; en = 1'b1;
    st = 0;
    while (!bit_clk && st < 100) begin step(); st++; end
    chk("R9 first rising edge 1.5 periods after enable", st, p + p / 2);
    c0 = cap_n;
    ex[0] = w;
    send(w[31:16], w[15:0]);
    expect_seq("R6 word at new divisor", c0, prev, 1);
    chk("R6 high half of clamped period", last_hi, p / 2);
    chk("R6 rise spacing", last_rr, p);
    chk("R4 strobe width one period", last_llw, p);
    chk("R1 data stable at rising edges", viol, 0);
  endtask

  task automatic t_disable();
    logic [4:0] seen;
    en = 1'b0; step();
    seen = '0;
    for (int i = 0; i < 10; i++) begin
      seen |= {bit_clk, ser_left, ser_right, lat_left, lat_right};
      if (s_ready) seen[0] = 1'b1;
      step();
    end
    chk("R9 outputs low while disabled", {27'd0, seen}, 32'd0);
    chk("R9 s_ready low while disabled", {31'd0, s_ready}, 32'd0);
  endtask

  task automatic t_coincide();
    int c0, idx;
    div_cfg = 12'd4; en = 1'b1;
    wait_caps(cap_n + 2);
    c0 = cap_n;
    while (cap_n == c0) step();
    repeat (3) step();
    chk("R10 ready in frame-start cycle", {31'd0, s_ready}, 32'd1);
    s_valid = 1'b1; s_left = 16'h1357; s_right = 16'hFDB9;
    step();
    s_valid = 1'b0;
    idx = cap_n;
    wait_caps(idx + 1);
    chk("R10 coincident pair in same frame", {cap_l[idx], cap_r[idx]}, 32'h1357_FDB9);
    ex[0] = 32'h2468_0ACE;
    send(16'h2468, 16'h0ACE);
    expect_seq("R10 no second copy from buffer", idx + 1, 32'h1357_FDB9, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_idle_zero();
    t_stream();
    t_div(12'd6, 6, 32'hA5C3_3C5A, 32'h0F0F_F0F0);
    t_div(12'd5, 2, 32'h0F0F_F0F0, 32'h4001_BFFE);
    t_div(12'd0, 2, 32'h4001_BFFE, 32'hFFFE_0002);
    t_disable();
    t_coincide();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule